// File: doc/BRIEF.md
# Relative Branch Resolver with Bit-Test Branches

This block settles the outcome of a relative branch for an 8-bit processor core. The core pulses `start_i` once the branch operands are in hand: the opcode, the program counter already advanced past the instruction, the signed 8-bit displacement, the zero-page byte read for a bit-test branch, and, for an ordinary conditional branch, the condition outcome the core has already worked out. One clock later the block presents the next program counter, whether the branch was taken, and the cycle count the instruction costs. It then pulses `done_o` for a single clock.

Two branch families are handled. A bit-test branch, marked by an opcode whose low nibble is all ones, picks one bit of the memory byte through three opcode bits and compares it with a polarity given by the opcode's top bit. It always costs a fixed count. An ordinary branch follows the supplied condition and charges a penalty that grows when the target lands on a different 256-byte page. The block reads and writes no status flags. The results stay in output registers until the next start.

Top module: `branch_resolver`

## Requirements
- R1: While reset is asserted and after it is released, with no start yet, `done_o`, `taken_o`, `next_pc_o` and `cycles_o` are all zero.
- R2: `done_o` is high for exactly the one clock that follows each clock in which `start_i` was high, and is low otherwise.
- R3: `next_pc_o`, `taken_o` and `cycles_o` change only in the clock after a start and otherwise keep their values, whatever the inputs do.
- R4: An opcode with bits [3:0] equal to 4'hF is a bit-test branch. Its bits [6:4] give the index (0 to 7) of the tested bit of `mem_byte_i`.
- R5: For a bit-test branch, opcode bit 7 = 0 takes the branch when the tested bit is 0, and bit 7 = 1 takes it when the tested bit is 1.
- R6: When a branch is taken, `next_pc_o` is `pc_i` plus `disp_i` sign-extended to 16 bits, wrapping modulo 65536.
- R7: When a branch is not taken, `next_pc_o` equals `pc_i`.
- R8: A bit-test branch reports `cycles_o` = 5 whether or not it is taken, and whether or not the target crosses a page.
- R9: Any other opcode is an ordinary branch with `taken_o` = `cond_i`. It reports 2 cycles when not taken, 3 when taken to a target whose bits [15:8] match those of `pc_i`, and 4 when taken to a target on another page.
- R10: Ordinary branches ignore `mem_byte_i`, and bit-test branches ignore `cond_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-clock request to resolve a branch |
| opcode_i | input | 8 | Branch opcode |
| pc_i | input | 16 | Program counter pointing past the instruction |
| disp_i | input | 8 | Signed two's-complement displacement |
| mem_byte_i | input | 8 | Zero-page byte tested by a bit-test branch |
| cond_i | input | 1 | Condition outcome for an ordinary branch |
| next_pc_o | output | 16 | Resolved next program counter |
| taken_o | output | 1 | Branch was taken |
| cycles_o | output | 4 | Cycle count of the instruction |
| done_o | output | 1 | One-clock pulse with valid results |

## Verification
A wrong bit index or an inverted polarity in the bit tester shows up as a flipped `taken_o` and a `next_pc_o` that is off by the displacement. It is visible on the first clock after the start that exercises that opcode and bit pattern, which is why every bit-test opcode is swept against every byte value. A page-cross detector that compares the wrong bytes, or a sign extension that drops the top bit, appears as a wrong `cycles_o` or target on that same clock, but only for displacements that cross a page boundary or point backward. A stuck output enable shows as results that drift while inputs change between starts, or as a `done_o` that lasts longer than one clock.

// File: rtl/brres_pkg.sv
package brres_pkg;

  localparam int unsigned OPC_W     = 8;
  localparam int unsigned SEL_W     = 3;
  localparam logic [3:0]  BIT_NIBBLE = 4'hF;

  typedef enum logic [0:0] {
    KIND_PLAIN   = 1'b0,
    KIND_BITTEST = 1'b1
  } br_kind_e;

  typedef struct packed {
    br_kind_e          kind;
    logic [SEL_W-1:0]  bit_sel;
    logic              want_set;
  } br_decode_t;

  function automatic br_decode_t decode_opcode(input logic [OPC_W-1:0] opc);
    br_decode_t d;
    d.kind     = (opc[3:0] == BIT_NIBBLE) ? KIND_BITTEST : KIND_PLAIN;
    d.bit_sel  = opc[6:4];
    d.want_set = opc[7];
    return d;
  endfunction

endpackage

// File: rtl/brres_bit_test.sv
module brres_bit_test #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SEL_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              want_set_i,
  output logic              hit_o
);

  logic [DATA_W-1:0] match_w;

  // One comparator per bit position; the index picks one result.
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign match_w[g] = (data_i[g] == want_set_i);
  end

  assign hit_o = match_w[sel_i];

endmodule

// File: rtl/brres_target.sv
module brres_target #(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned HI_W  = PC_W - PAGE_W
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [PC_W-1:0]   target_o,
  output logic              crossed_o
);

  function automatic logic [PC_W-1:0] sext(input logic [DISP_W-1:0] d);
    return {{(PC_W-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [HI_W-1:0] page_of(input logic [PC_W-1:0] a);
    return a[PC_W-1:PAGE_W];
  endfunction

  assign target_o  = pc_i + sext(disp_i);
  assign crossed_o = (page_of(target_o) != page_of(pc_i));

endmodule

// File: rtl/brres_cycles.sv
module brres_cycles
  import brres_pkg::*;
#(
  parameter int unsigned CYC_W      = 4,
  parameter int unsigned BIT_CYC    = 5,
  parameter int unsigned PLAIN_BASE = 2
) (
  input  br_kind_e         kind_i,
  input  logic             taken_i,
  input  logic             crossed_i,
  output logic [CYC_W-1:0] cycles_o
);

  function automatic logic [CYC_W-1:0] plain_cost(input logic tk, input logic cr);
    logic [CYC_W-1:0] extra;
    extra = tk ? (cr ? CYC_W'(2) : CYC_W'(1)) : '0;
    return CYC_W'(PLAIN_BASE) + extra;
  endfunction

  always_comb begin
    if (kind_i == KIND_BITTEST) cycles_o = CYC_W'(BIT_CYC);
    else                        cycles_o = plain_cost(taken_i, crossed_i);
  end

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brres_pkg::*;
#(
  parameter int unsigned PC_W       = 16,
  parameter int unsigned DISP_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_W     = 8,
  parameter int unsigned CYC_W      = 4,
  parameter int unsigned BIT_CYC    = 5,
  parameter int unsigned PLAIN_BASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [DATA_W-1:0] mem_byte_i,
  input  logic              cond_i,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              taken_o,
  output logic [CYC_W-1:0]  cycles_o,
  output logic              done_o
);

  localparam int unsigned SEL_W = $clog2(DATA_W);

  // Named internal events, visible to the bound checker.
  br_decode_t        dec_w;
  br_kind_e          kind_w;
  logic              bit_hit_w;
  logic              page_cross_w;
  logic              taken_w;
  logic [PC_W-1:0]   target_w;
  logic [PC_W-1:0]   npc_w;
  logic [CYC_W-1:0]  cyc_w;

  assign dec_w  = decode_opcode(opcode_i);
  assign kind_w = dec_w.kind;

  brres_bit_test #(.DATA_W(DATA_W)) u_bit (
    .data_i     (mem_byte_i),
    .sel_i      (SEL_W'(dec_w.bit_sel)),
    .want_set_i (dec_w.want_set),
    .hit_o      (bit_hit_w)
  );

  brres_target #(.PC_W(PC_W), .DISP_W(DISP_W), .PAGE_W(PAGE_W)) u_tgt (
    .pc_i      (pc_i),
    .disp_i    (disp_i),
    .target_o  (target_w),
    .crossed_o (page_cross_w)
  );

  assign taken_w = (kind_w == KIND_BITTEST) ? bit_hit_w : cond_i;
  assign npc_w   = taken_w ? target_w : pc_i;

  brres_cycles #(.CYC_W(CYC_W), .BIT_CYC(BIT_CYC), .PLAIN_BASE(PLAIN_BASE)) u_cyc (
    .kind_i    (kind_w),
    .taken_i   (taken_w),
    .crossed_i (page_cross_w),
    .cycles_o  (cyc_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc_o <= '0;
      taken_o   <= 1'b0;
      cycles_o  <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        next_pc_o <= npc_w;
        taken_o   <= taken_w;
        cycles_o  <= cyc_w;
      end
    end
  end

endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk
  import brres_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned CYC_W = 4,
  parameter int unsigned BIT_CYC = 5,
  parameter int unsigned PLAIN_BASE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [7:0]        opcode_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [DISP_W-1:0] disp_i,
  input logic              cond_i,
  input logic              page_cross_w,
  input logic [PC_W-1:0]   next_pc_o,
  input logic              taken_o,
  input logic [CYC_W-1:0]  cycles_o,
  input logic              done_o
);

  p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);

  p_hold_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(next_pc_o) && $stable(taken_o) && $stable(cycles_o)));

  p_not_taken_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (taken_o || next_pc_o == $past(pc_i)));

  p_taken_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!taken_o ||
      next_pc_o == PC_W'($past(pc_i) + {{(PC_W-DISP_W){$past(disp_i[DISP_W-1])}}, $past(disp_i)})));

  p_bit_fixed_cycles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && opcode_i[3:0] == 4'hF) |=> cycles_o == CYC_W'(BIT_CYC));

  p_plain_follows_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && opcode_i[3:0] != 4'hF) |=> taken_o == $past(cond_i));

  p_plain_cross_cost_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && opcode_i[3:0] != 4'hF && cond_i && page_cross_w)
      |=> cycles_o == CYC_W'(PLAIN_BASE + 2));

endmodule

bind branch_resolver branch_resolver_chk #(
  .PC_W(PC_W), .DISP_W(DISP_W), .CYC_W(CYC_W),
  .BIT_CYC(BIT_CYC), .PLAIN_BASE(PLAIN_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
  .pc_i(pc_i), .disp_i(disp_i), .cond_i(cond_i), .page_cross_w(page_cross_w),
  .next_pc_o(next_pc_o), .taken_o(taken_o), .cycles_o(cycles_o), .done_o(done_o)
);

// File: tb/branch_resolver_test.sv
`timescale 1ns/1ps
module branch_resolver_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  disp_i = '0;
  logic [7:0]  mem_byte_i = '0;
  logic        cond_i = 1'b0;
  logic [15:0] next_pc_o;
  logic        taken_o;
  logic [3:0]  cycles_o;
  logic        done_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  branch_resolver uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .pc_i(pc_i), .disp_i(disp_i), .mem_byte_i(mem_byte_i), .cond_i(cond_i),
    .next_pc_o(next_pc_o), .taken_o(taken_o), .cycles_o(cycles_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bench-side model of the target address.
  function automatic logic [15:0] exp_target(input logic [15:0] pc, input logic [7:0] d);
    int signed off;
    off = (d >= 8'd128) ? int'(d) - 256 : int'(d);
    return 16'((int'(pc) + off + 65536) % 65536);
  endfunction

  // Issue one request and capture results plus both done samples.
  task automatic run_op(input logic [7:0] op, input logic [15:0] pc, input logic [7:0] d,
                        input logic [7:0] mb, input logic c,
                        output logic [15:0] npc, output logic tk, output logic [3:0] cy,
                        output logic dn1, output logic dn2);
    @(negedge clk);
    opcode_i = op; pc_i = pc; disp_i = d; mem_byte_i = mb; cond_i = c; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    npc = next_pc_o; tk = taken_o; cy = cycles_o; dn1 = done_o;
    @(negedge clk);
    dn2 = done_o;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(done_o == 1'b0 && taken_o == 1'b0, "R1", "done/taken in reset", {done_o, taken_o}, 0);
    check(next_pc_o == 16'h0 && cycles_o == 4'h0, "R1", "pc/cycles in reset", {next_pc_o, cycles_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done_o == 1'b0 && next_pc_o == 16'h0, "R1", "idle after reset", {done_o, next_pc_o}, 0);
  endtask

  // Every bit-test opcode against every byte value.
  task automatic t_bit_sweep();
    logic [15:0] npc; logic tk, dn1, dn2; logic [3:0] cy;
    for (int hi = 0; hi < 16; hi++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] op;
        logic exp_tk;
        logic [15:0] pc;
        logic [7:0] d;
        op = {hi[3:0], 4'hF};
        pc = 16'h4000 + 16'(v * 3);
        d  = 8'(v ^ 8'h5A);
        exp_tk = (((v >> (hi % 8)) & 1) == (hi / 8));
        run_op(op, pc, d, 8'(v), ~exp_tk, npc, tk, cy, dn1, dn2);
        check(tk == exp_tk, "R4 R5 R10", $sformatf("taken op %02h byte %02h", op, v), tk, exp_tk);
        if (exp_tk)
          check(npc == exp_target(pc, d), "R6", "bit target", npc, exp_target(pc, d));
        else
          check(npc == pc, "R7", "bit not-taken pc", npc, pc);
        check(cy == 4'd5, "R8", "bit cycles", cy, 5);
        if (v == 0) begin
          check(dn1 == 1'b1 && dn2 == 1'b0, "R2", "done pulse", {dn1, dn2}, 2'b10);
        end
      end
    end
  endtask

  task automatic t_plain();
    logic [15:0] npc; logic tk, dn1, dn2; logic [3:0] cy;
    run_op(8'hD0, 16'h1240, 8'h10, 8'h00, 1'b0, npc, tk, cy, dn1, dn2);
    check(!tk && npc == 16'h1240 && cy == 4'd2, "R7 R9", "plain not taken", {tk, npc, cy}, {1'b0, 16'h1240, 4'd2});
    run_op(8'hD0, 16'h1240, 8'h10, 8'h00, 1'b1, npc, tk, cy, dn1, dn2);
    check(tk && npc == 16'h1250 && cy == 4'd3, "R6 R9", "plain same page", {tk, npc, cy}, {1'b1, 16'h1250, 4'd3});
    check(dn1 && !dn2, "R2", "plain done pulse", {dn1, dn2}, 2'b10);
  endtask

  task automatic t_page_cross();
    logic [15:0] npc; logic tk, dn1, dn2; logic [3:0] cy;
    run_op(8'h10, 16'h12F0, 8'h20, 8'h00, 1'b1, npc, tk, cy, dn1, dn2);
    check(npc == 16'h1310 && cy == 4'd4, "R6 R9", "forward cross", {npc, cy}, {16'h1310, 4'd4});
    run_op(8'h30, 16'h1205, 8'hF0, 8'h00, 1'b1, npc, tk, cy, dn1, dn2);
    check(npc == 16'h11F5 && cy == 4'd4, "R6 R9", "backward cross", {npc, cy}, {16'h11F5, 4'd4});
    run_op(8'h90, 16'h1250, 8'h80, 8'h00, 1'b1, npc, tk, cy, dn1, dn2);
    check(npc == 16'h11D0 && cy == 4'd4, "R6 R9", "most negative disp", {npc, cy}, {16'h11D0, 4'd4});
    run_op(8'hB0, 16'hFFF0, 8'h7F, 8'h00, 1'b1, npc, tk, cy, dn1, dn2);
    check(npc == 16'h006F && cy == 4'd4, "R6 R9", "wrap past top", {npc, cy}, {16'h006F, 4'd4});
    // Bit-test branch set on bit 7, byte 0x80, crossing backward: still 5.
    run_op(8'hFF, 16'h2003, 8'hF0, 8'h80, 1'b0, npc, tk, cy, dn1, dn2);
    check(tk && npc == 16'h1FF3 && cy == 4'd5, "R8", "bit cross fixed cost", {tk, npc, cy}, {1'b1, 16'h1FF3, 4'd5});
  endtask

  task automatic t_hold();
    logic [15:0] npc; logic tk, dn1, dn2; logic [3:0] cy;
    run_op(8'h70, 16'h3456, 8'h22, 8'h00, 1'b1, npc, tk, cy, dn1, dn2);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      opcode_i = 8'(k * 37); pc_i = 16'(k * 4099); disp_i = 8'(k * 91);
      mem_byte_i = 8'(k * 13); cond_i = k[0];
    end
    @(negedge clk);
    check(next_pc_o == 16'h3478 && taken_o && cycles_o == 4'd3, "R3", "hold between starts",
          {next_pc_o, taken_o, cycles_o}, {16'h3478, 1'b1, 4'd3});
    check(done_o == 1'b0, "R2", "no done without start", done_o, 0);
  endtask

  task automatic t_ignore();
    logic [15:0] npc; logic tk, dn1, dn2; logic [3:0] cy;
    run_op(8'hF0, 16'h5000, 8'h04, 8'hFF, 1'b0, npc, tk, cy, dn1, dn2);
    check(!tk && npc == 16'h5000 && cy == 4'd2, "R10", "plain ignores byte ones", {tk, npc, cy}, {1'b0, 16'h5000, 4'd2});
    run_op(8'hF0, 16'h5000, 8'h04, 8'h00, 1'b1, npc, tk, cy, dn1, dn2);
    check(tk && npc == 16'h5004, "R10", "plain ignores byte zeros", {tk, npc}, {1'b1, 16'h5004});
    run_op(8'h0F, 16'h6000, 8'h08, 8'h01, 1'b1, npc, tk, cy, dn1, dn2);
    check(!tk && npc == 16'h6000, "R10", "bit ignores cond", {tk, npc}, {1'b0, 16'h6000});
  endtask

  initial begin
    #500000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_bit_sweep();
    t_plain();
    t_page_cross();
    t_hold();
    t_ignore();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule